// File: doc/BRIEF.md
# Successive-Approximation Converter Controller

This block is the digital half of an 8-bit successive-approximation analog-to-digital converter in a microcontroller. Software sees three byte-wide registers through a simple write strobe and a combinational read port: a control/status register, a result register and a divider register that sets the conversion clock. The block drives a channel select for a four-way analog multiplexer and a sample/hold control. It presents a trial code to an external resistor-ladder DAC and reads back a single comparator decision.

A conversion starts when software writes the start bit. The selected input is sampled for a fixed number of conversion clocks and then held. The code is then resolved one bit at a time, most significant bit first, with eight conversion clocks per bit. At the end the code goes into the result register, the done flag rises and a one-clock low pulse is produced. An external routing control decides whether that pulse or the external interrupt pin drives the INT1 line.

Register map (addr_i): 0 = control/status, 1 = result (read-only), 2 = divider. Control bits: [1:0] channel, [2] start (write 1 to start; reads 1 for one cycle), [3] done (read-only), [4] busy (read-only). Unmapped addresses read 0.

Top module: `sar_adc_ctrl`

## Requirements
- R1: For a static input value v on the selected channel and a comparator that reports 1 when the input is at or above dac_code_o, the result register (addr 1) reads v after the conversion. The code is resolved MSB first, and a trial bit is kept when the comparator reads 1 at the end of its bit period.
- R2: Control bits [1:0] written with a start request drive chan_o, and chan_o keeps that value for the whole conversion.
- R3: One conversion clock lasts 2*(D+1) system clocks, where D is the divider register (addr 2). The done flag (control bit 3) rises at the clock edge 72*2*(D+1) edges after the edge that takes the start write: 8 sample clocks plus 8 bits of 8 clocks each.
- R4: The start bit (control bit 2) reads 1 for exactly one cycle after the start write and reads 0 after that.
- R5: The done flag is cleared when a conversion starts, stays 0 while busy (control bit 4) is 1, and is set at the edge that loads the result.
- R6: sample_o is 1 for exactly the first 8 conversion clocks of a conversion and 0 during all bit trials and while idle.
- R7: A control write with the start bit set while busy is 1 has no effect: the channel, the running conversion, its timing and its result are unchanged.
- R8: The completion interrupt idles high and goes low for exactly one system clock, at the same edge the done flag is set.
- R9: With irq_route_i = 1, int1_o carries the completion interrupt and ignores int1_pin_i. With irq_route_i = 0, int1_o follows int1_pin_i and the completion pulse does not appear on it.
- R10: The result register keeps its value during a later conversion until that conversion completes.
- R11: After reset, the control, result and divider registers read 0, chan_o is 0, sample_o is 0 and dac_code_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data (combinational) |
| chan_o | output | 2 | Analog multiplexer select |
| sample_o | output | 1 | 1 = sample, 0 = hold |
| dac_code_o | output | 8 | Trial code to ladder DAC |
| cmp_i | input | 1 | Comparator: 1 when input is at or above ladder |
| irq_route_i | input | 1 | 1 = completion pulse drives INT1 |
| int1_pin_i | input | 1 | External interrupt pin |
| int1_o | output | 1 | INT1 line to the interrupt controller |

## Verification
If a bit is lost or kept wrongly in the approximation register, the wrong value shows in the result register as soon as the conversion completes. The width of that error shows which trial failed. If the tick counter or the divider is off, the done flag and the low pulse on int1_o move from their exact edge, so one stretched conversion clock already shows. If the sequencer phase is wrong, sample_o is high for the wrong number of cycles or a start request is taken while busy. Both of these show within the conversion where they happen.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SAMPLE = 2'd1,
    PH_TRIAL  = 2'd2
  } phase_e;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_RES  = 2'd1;
  localparam logic [1:0] ADDR_DIV  = 2'd2;

  localparam int CTRL_START_BIT = 2;
  localparam int CTRL_DONE_BIT  = 3;
  localparam int CTRL_BUSY_BIT  = 4;
endpackage

// File: rtl/sar_adc_clkdiv.sv
module sar_adc_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  localparam int CNT_W = DIV_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] top;

  // period 2*(div+1) -> terminal count 2*div+1
  assign top    = {div_i, 1'b1};
  assign tick_o = en_i && (cnt_q == top);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (en_i) begin
      cnt_q <= (cnt_q == top) ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sar_adc_core.sv
module sar_adc_core
  import sar_adc_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 8,
  parameter int SAMPLE_TICKS  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              tick_i,
  input  logic              cmp_i,
  output logic              busy_o,
  output logic              sample_o,
  output logic [DATA_W-1:0] code_o,
  output logic              fin_o,
  output logic [DATA_W-1:0] final_o
);
  localparam int MAX_T  = (TICKS_PER_BIT > SAMPLE_TICKS) ? TICKS_PER_BIT : SAMPLE_TICKS;
  localparam int TCNT_W = $clog2(MAX_T + 1);
  localparam int BIT_W  = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [TCNT_W-1:0] BIT_LAST    = TCNT_W'(TICKS_PER_BIT - 1);
  localparam logic [TCNT_W-1:0] SAMPLE_LAST = TCNT_W'(SAMPLE_TICKS - 1);
  localparam logic [BIT_W-1:0]  MSB_IDX     = BIT_W'(DATA_W - 1);
  localparam logic [DATA_W-1:0] ONE         = {{(DATA_W-1){1'b0}}, 1'b1};

  phase_e             phase_q;
  logic [TCNT_W-1:0]  tcnt_q;
  logic [BIT_W-1:0]   bit_q;
  logic [DATA_W-1:0]  code_q;
  logic [DATA_W-1:0]  next_code;
  logic [DATA_W-1:0]  clr_mask;
  logic [DATA_W-1:0]  set_mask;
  logic               bit_end;

  assign bit_end = (phase_q == PH_TRIAL) && tick_i && (tcnt_q == BIT_LAST);

  always_comb begin
    clr_mask  = ~(ONE << bit_q);
    set_mask  = (bit_q == '0) ? '0 : (ONE << (bit_q - 1'b1));
    next_code = (cmp_i ? code_q : (code_q & clr_mask)) | set_mask;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      tcnt_q  <= '0;
      bit_q   <= MSB_IDX;
      code_q  <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          if (start_i) begin
            phase_q <= PH_SAMPLE;
            tcnt_q  <= '0;
            bit_q   <= MSB_IDX;
            code_q  <= '0;
          end
        end
        PH_SAMPLE: begin
          if (tick_i) begin
            if (tcnt_q == SAMPLE_LAST) begin
              phase_q <= PH_TRIAL;
              tcnt_q  <= '0;
              code_q  <= ONE << MSB_IDX;
            end else begin
              tcnt_q <= tcnt_q + 1'b1;
            end
          end
        end
        PH_TRIAL: begin
          if (tick_i) begin
            if (tcnt_q == BIT_LAST) begin
              tcnt_q <= '0;
              code_q <= next_code;
              if (bit_q == '0) phase_q <= PH_IDLE;
              else             bit_q   <= bit_q - 1'b1;
            end else begin
              tcnt_q <= tcnt_q + 1'b1;
            end
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign busy_o   = (phase_q != PH_IDLE);
  assign sample_o = (phase_q == PH_SAMPLE);
  assign code_o   = code_q;
  assign fin_o    = bit_end && (bit_q == '0);
  assign final_o  = next_code;
endmodule

// File: rtl/sar_adc_regs.sv
module sar_adc_regs
  import sar_adc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8,
  parameter int CH_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic              busy_i,
  input  logic              fin_i,
  input  logic [DATA_W-1:0] final_i,
  output logic              start_o,
  output logic              start_q_o,
  output logic              done_o,
  output logic              irq_n_o,
  output logic [CH_W-1:0]   chan_o,
  output logic [DIV_W-1:0]  div_o,
  output logic [DATA_W-1:0] result_o
);
  logic              wr_ctrl;
  logic              accept;
  logic [CH_W-1:0]   chan_q;
  logic              start_q;
  logic              done_q;
  logic              irq_n_q;
  logic [DIV_W-1:0]  div_q;
  logic [DATA_W-1:0] result_q;

  assign wr_ctrl = wr_en_i && (addr_i == ADDR_CTRL);
  assign accept  = wr_ctrl && wdata_i[CTRL_START_BIT] && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chan_q   <= '0;
      start_q  <= 1'b0;
      done_q   <= 1'b0;
      irq_n_q  <= 1'b1;
      div_q    <= '0;
      result_q <= '0;
    end else begin
      start_q <= accept;
      irq_n_q <= !fin_i;
      if (wr_ctrl && !busy_i) chan_q <= wdata_i[CH_W-1:0];
      if (wr_en_i && (addr_i == ADDR_DIV)) div_q <= wdata_i[DIV_W-1:0];
      if (accept)     done_q <= 1'b0;
      else if (fin_i) done_q <= 1'b1;
      if (fin_i) result_q <= final_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_CTRL: begin
        rdata_o[CH_W-1:0]      = chan_q;
        rdata_o[CTRL_START_BIT] = start_q;
        rdata_o[CTRL_DONE_BIT]  = done_q;
        rdata_o[CTRL_BUSY_BIT]  = busy_i;
      end
      ADDR_RES: rdata_o[DATA_W-1:0] = result_q;
      ADDR_DIV: rdata_o[DIV_W-1:0]  = div_q;
      default:  rdata_o = '0;
    endcase
  end

  assign start_o   = accept;
  assign start_q_o = start_q;
  assign done_o    = done_q;
  assign irq_n_o   = irq_n_q;
  assign chan_o    = chan_q;
  assign div_o     = div_q;
  assign result_o  = result_q;
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl #(
  parameter int DATA_W        = 8,
  parameter int DIV_W         = 8,
  parameter int CH_W          = 2,
  parameter int TICKS_PER_BIT = 8,
  parameter int SAMPLE_TICKS  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic [CH_W-1:0]   chan_o,
  output logic              sample_o,
  output logic [DATA_W-1:0] dac_code_o,
  input  logic              cmp_i,
  input  logic              irq_route_i,
  input  logic              int1_pin_i,
  output logic              int1_o
);
  logic              start;
  logic              start_q;
  logic              busy;
  logic              tick;
  logic              fin;
  logic              done_q;
  logic              irq_n;
  logic [DATA_W-1:0] final_code;
  logic [DATA_W-1:0] result_q;
  logic [DIV_W-1:0]  div;

  sar_adc_regs #(.DATA_W(DATA_W), .DIV_W(DIV_W), .CH_W(CH_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .rdata_o   (rdata_o),
    .busy_i    (busy),
    .fin_i     (fin),
    .final_i   (final_code),
    .start_o   (start),
    .start_q_o (start_q),
    .done_o    (done_q),
    .irq_n_o   (irq_n),
    .chan_o    (chan_o),
    .div_o     (div),
    .result_o  (result_q)
  );

  sar_adc_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start),
    .en_i   (busy),
    .div_i  (div),
    .tick_o (tick)
  );

  sar_adc_core #(
    .DATA_W        (DATA_W),
    .TICKS_PER_BIT (TICKS_PER_BIT),
    .SAMPLE_TICKS  (SAMPLE_TICKS)
  ) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .tick_i   (tick),
    .cmp_i    (cmp_i),
    .busy_o   (busy),
    .sample_o (sample_o),
    .code_o   (dac_code_o),
    .fin_o    (fin),
    .final_o  (final_code)
  );

  assign int1_o = irq_route_i ? irq_n : int1_pin_i;
endmodule

// File: rtl/sar_adc_ctrl_chk.sv
module sar_adc_ctrl_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [1:0]        addr_i,
  input logic [7:0]        wdata_i,
  input logic              sample_o,
  input logic [DATA_W-1:0] dac_code_o,
  input logic              busy,
  input logic              start_q,
  input logic              done_q,
  input logic              irq_n,
  input logic [DATA_W-1:0] result_q
);
  logic start_wr;
  assign start_wr = wr_en_i && (addr_i == 2'd0) && wdata_i[2];

  AST_START_SELF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_q |=> !start_q); // R4

  AST_DONE_LOW_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !done_q); // R5

  AST_SAMPLE_ONLY_IN_CONV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> busy); // R6

  AST_IRQ_SINGLE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_n |=> irq_n); // R8

  AST_IRQ_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_n |-> (done_q && !busy)); // R8

  AST_RESULT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(irq_n) |-> $stable(result_q)); // R10

  AST_IDLE_CODE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && !start_wr) |=> $stable(dac_code_o)); // R1
endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .sample_o   (sample_o),
  .dac_code_o (dac_code_o),
  .busy       (busy),
  .start_q    (start_q),
  .done_q     (done_q),
  .irq_n      (irq_n),
  .result_q   (result_q)
);

// File: tb/sar_adc_ctrl_test.sv
module sar_adc_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic [1:0] chan;
  logic       sample;
  logic [7:0] code;
  logic       cmp;
  logic       route = 1'b1;
  logic       pin = 1'b1;
  logic       int1;
  logic [7:0] ain [4];

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  assign cmp = (ain[chan] >= code);

  sar_adc_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .chan_o(chan), .sample_o(sample), .dac_code_o(code),
    .cmp_i(cmp), .irq_route_i(route), .int1_pin_i(pin), .int1_o(int1)
  );

  // {chan, divider, input}
  localparam logic [17:0] VEC [8] = '{
    {2'd0, 8'd0, 8'd0},   {2'd1, 8'd0, 8'd255}, {2'd2, 8'd1, 8'd128},
    {2'd3, 8'd0, 8'd127}, {2'd0, 8'd2, 8'd1},   {2'd1, 8'd0, 8'hAA},
    {2'd2, 8'd3, 8'h55},  {2'd3, 8'd1, 8'h3C}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1 wr_en = 1'b0; addr = 2'd0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; #1 d = rdata;
    addr = 2'd0;
  endtask

  // runs one conversion; returns cycles to done, sample-high count, irq pulse width
  task automatic convert(input logic [1:0] ch, input logic [7:0] dv, input bit hit_busy,
                         output int cyc, output int samp, output int low);
    logic [7:0] s;
    @(negedge clk);
    wr_en = 1'b1; addr = 2'd0; wdata = {5'b00000, 1'b1, ch};
    @(posedge clk);
    cyc = 1; samp = 0; low = 0;
    @(negedge clk);
    wr_en = 1'b0;
    s = rdata;
    check(s[2] == 1'b1, "R4 start reads 1", s[2], 1);
    check(s[3] == 1'b0 && s[4] == 1'b1, "R5 done clear busy set", s[4:3], 2);
    if (sample) samp++;
    @(posedge clk); cyc++;
    @(negedge clk);
    check(rdata[2] == 1'b0, "R4 start self-clears", rdata[2], 0);
    if (sample) samp++;
    while (rdata[3] == 1'b0 && cyc < 20000) begin
      if (hit_busy && cyc == 40) begin
        wr_en = 1'b1; wdata = {5'b00000, 1'b1, ~ch};
      end else begin
        wr_en = 1'b0;
      end
      @(posedge clk); cyc++;
      @(negedge clk);
      if (int1 == 1'b0) low++;
      if (rdata[3] == 1'b0) begin
        if (sample) samp++;
        if (chan != ch) begin
          check(1'b0, "R2/R7 channel held", chan, ch);
        end
      end
    end
    check(rdata[4] == 1'b0, "R5 busy clear at done", rdata[4], 0);
    @(posedge clk);
    @(negedge clk);
    if (int1 == 1'b0) low++;
    cyc = cyc - 1;
    if (dv == 8'hFF) cyc = -1;
  endtask

  initial begin : wdog
    repeat (190000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : main
    logic [7:0] r;
    int cyc, samp, low, expc;
    ain[0] = 8'd10; ain[1] = 8'd20; ain[2] = 8'd30; ain[3] = 8'd40;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    check(chan == 2'd0 && sample == 1'b0 && code == 8'd0, "R11 outputs", {chan, sample, code}, 0);
    rd(2'd0, r); check(r == 8'd0, "R11 ctrl", r, 0);
    rd(2'd1, r); check(r == 8'd0, "R11 result", r, 0);
    rd(2'd2, r); check(r == 8'd0, "R11 divider", r, 0);
    rst_n = 1'b1;
    check(int1 == 1'b1, "R8 idle high", int1, 1);

    for (int i = 0; i < 8; i++) begin
      logic [1:0] ch; logic [7:0] dv, v;
      {ch, dv, v} = VEC[i];
      ain[ch] = v;
      wr(2'd2, dv);
      rd(2'd2, r); check(r == dv, "R3 divider readback", r, dv);
      convert(ch, 8'd0, 1'b0, cyc, samp, low);
      expc = 72 * 2 * (dv + 1);
      check(cyc == expc, "R3 conversion time", cyc, expc);
      check(samp == 16 * (dv + 1), "R6 sample window", samp, 16 * (dv + 1));
      check(low == 1, "R8/R9 one-cycle pulse on int1", low, 1);
      check(chan == ch, "R2 channel output", chan, ch);
      rd(2'd1, r); check(r == v, "R1 result", r, v);
      check(sample == 1'b0, "R6 hold when idle", sample, 0);
    end

    // R10: result held during a later conversion
    ain[1] = 8'd99;
    wr(2'd2, 8'd0);
    @(negedge clk);
    wr_en = 1'b1; addr = 2'd0; wdata = 8'h05;
    @(posedge clk); #1 wr_en = 1'b0;
    repeat (60) @(posedge clk);
    rd(2'd1, r); check(r == 8'h3C, "R10 result held mid-conversion", r, 8'h3C);
    repeat (100) @(posedge clk);
    rd(2'd1, r); check(r == 8'd99, "R10 result updated", r, 99);

    // R7: start while busy ignored
    ain[2] = 8'd77; ain[1] = 8'd200;
    convert(2'd2, 8'd0, 1'b1, cyc, samp, low);
    check(cyc == 144, "R7 timing unchanged", cyc, 144);
    rd(2'd1, r); check(r == 8'd77, "R7 result from first request", r, 77);
    rd(2'd0, r); check(r[1:0] == 2'd2, "R7 channel unchanged", r[1:0], 2);

    // R9: pin routing
    route = 1'b0;
    pin = 1'b0; #1 check(int1 == 1'b0, "R9 pin low passes", int1, 0);
    pin = 1'b1; #1 check(int1 == 1'b1, "R9 pin high passes", int1, 1);
    convert(2'd0, 8'd0, 1'b0, cyc, samp, low);
    check(low == 0, "R9 pulse hidden when unrouted", low, 0);
    route = 1'b1;
    pin = 1'b0; #1 check(int1 == 1'b1, "R9 pin ignored when routed", int1, 1);
    pin = 1'b1;

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule